// File: doc/BRIEF.md
# Gated-Clock Parallel/Serial-In Shift Register

A register of `WIDTH` stages (eight by default) that takes data either in parallel or one bit at a time, and presents one bit at its serial output: the last stage. A single mode input selects what happens at each active clock edge. In shift mode, every stage passes its value one position toward the output, and the first stage captures the serial input. In load mode, every stage captures its own bit of the parallel word. The load is synchronous: it waits for the active edge and does not act at the moment the mode changes.

The active edge comes from a two-input NOR of `clk_in` and `clk_hold`. The register advances on the rising edge of that NOR. In practice this is a falling edge of one input while the other input sits low. Either input can therefore serve as the clock, and the other then acts as an inhibit. `clk_hold` must only change while `clk_in` is high, so that no false edge is produced.

An active-low clear acts at once, without waiting for an edge. It forces every stage to zero and overrides the clock and all data inputs.

Top module: `piso_shreg`

## Requirements
- R1: While `clr_n` is 0, every stage is 0 and `ser_out` reads 0, at once and with no clock edge needed.
- R2: A gated clock edge that occurs while `clr_n` is 0 changes nothing: the stages stay 0 whatever the mode and data inputs are.
- R3: When `shift_mode` is 0 at an active edge, stage i takes `par_in[i]`. Afterwards `ser_out` shows `par_in[WIDTH-1]`.
- R4: With `shift_mode` at 0, a change of `par_in` between edges leaves `ser_out` unchanged until the next active edge.
- R5: When `shift_mode` is 1 at an active edge, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. After a load, `ser_out` therefore presents `par_in[WIDTH-1]` down to `par_in[0]` on successive shifts, followed by the serial bits in the order they entered.
- R6: During a parallel load, `ser_in` is ignored. No serial bit enters any stage.
- R7: The active edge is the rising edge of NOR(`clk_in`, `clk_hold`). With `clk_hold` held 0, a falling `clk_in` clocks the register. With `clk_in` held 0, a falling `clk_hold` clocks it.
- R8: While `clk_hold` is 1, the register does not change, whatever `clk_in`, `shift_mode`, `ser_in` and `par_in` do.
- R9: After `WIDTH` shifts with `ser_in` at 0, every stage is 0, and `ser_out` stays 0 on further such shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock input; one leg of the NOR gate |
| clk_hold | input | 1 | Clock inhibit, or the clock when `clk_in` is held low; other leg of the NOR gate |
| clr_n | input | 1 | Active-low direct clear, asynchronous, highest priority |
| shift_mode | input | 1 | 1 = shift at the next edge, 0 = parallel load at the next edge |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel data; bit i goes to stage i |
| ser_out | output | 1 | Value of the last stage, `WIDTH-1` |

## Verification
The bench builds the block with the default `WIDTH` of 8. At that width, a complete load followed by a full drain takes only nine active edges. This lets every loaded bit and every serially entered bit be seen at `ser_out` many times within a short run.

The bench also swaps the roles of the two gate inputs at run time. This exercises the inhibit leg acting as the clock, and the hand-over between the two roles.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;

   typedef enum logic {
      MODE_LOAD  = 1'b0,
      MODE_SHIFT = 1'b1
   } piso_mode_e;

   function automatic piso_mode_e to_mode(input logic sel);
      return sel ? MODE_SHIFT : MODE_LOAD;
   endfunction

endpackage

// File: rtl/piso_clk_gate.sv
`timescale 1ns/1ps
module piso_clk_gate (
   input  logic clk_a,
   input  logic clk_b,
   output logic edge_clk
);
   // Rises only when both legs are low; either leg high blocks it.
   assign edge_clk = ~(clk_a | clk_b);
endmodule

// File: rtl/piso_stage.sv
`timescale 1ns/1ps
module piso_stage
   import piso_pkg::*;
(
   input  logic       edge_clk,
   input  logic       clr_n,
   input  piso_mode_e mode,
   input  logic       shift_src,
   input  logic       load_src,
   output logic       q
);
   always_ff @(posedge edge_clk or negedge clr_n) begin
      if (!clr_n) begin
         q <= 1'b0;
      end else if (mode == MODE_SHIFT) begin
         q <= shift_src;
      end else begin
         q <= load_src;
      end
   end
endmodule

// File: rtl/piso_shreg.sv
`timescale 1ns/1ps
module piso_shreg
   import piso_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk_in,
   input  logic             clk_hold,
   input  logic             clr_n,
   input  logic             shift_mode,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             ser_out
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_guard
      initial $fatal(1, "piso_shreg: WIDTH must be at least 2");
   end

   logic             edge_clk;
   logic [WIDTH-1:0] stage_q;
   logic [WIDTH-1:0] shift_src;
   piso_mode_e       mode;

   piso_clk_gate u_gate (
      .clk_a    (clk_in),
      .clk_b    (clk_hold),
      .edge_clk (edge_clk)
   );

   assign mode = to_mode(shift_mode);

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign shift_src[i] = ser_in;
      end else begin : g_body
         assign shift_src[i] = stage_q[i-1];
      end

      piso_stage u_stage (
         .edge_clk  (edge_clk),
         .clr_n     (clr_n),
         .mode      (mode),
         .shift_src (shift_src[i]),
         .load_src  (par_in[i]),
         .q         (stage_q[i])
      );
   end

   assign ser_out = stage_q[LAST];

endmodule

// File: rtl/piso_shreg_chk.sv
`timescale 1ns/1ps
module piso_shreg_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk_in,
   input logic             clk_hold,
   input logic             clr_n,
   input logic             shift_mode,
   input logic             ser_in,
   input logic [WIDTH-1:0] par_in,
   input logic             edge_clk,
   input logic [WIDTH-1:0] stage_q
);
   logic gate_armed;
   logic free_armed;

   always_ff @(posedge edge_clk or negedge clr_n) begin
      if (!clr_n) gate_armed <= 1'b0;
      else        gate_armed <= 1'b1;
   end

   always_ff @(posedge clk_in or negedge clr_n) begin
      if (!clr_n) free_armed <= 1'b0;
      else        free_armed <= 1'b1;
   end

   always @(posedge clk_in) begin
      if (clr_n === 1'b0) begin
         AST_CLEAR_ZERO: assert (stage_q == '0); // R1
      end
   end

   always @(posedge edge_clk) begin
      if (clr_n === 1'b0) begin
         AST_CLEAR_BEATS_EDGE: assert (stage_q == '0); // R2
      end
   end

   AST_LOAD_CAPTURE: assert property (@(posedge edge_clk) disable iff (!clr_n || !gate_armed)
      !shift_mode |=> stage_q == $past(par_in)); // R3

   AST_SHIFT_STEP: assert property (@(posedge edge_clk) disable iff (!clr_n || !gate_armed)
      shift_mode |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}); // R5

   AST_LOAD_NO_SERIAL: assert property (@(posedge edge_clk) disable iff (!clr_n || !gate_armed)
      !shift_mode |=> stage_q[0] == $past(par_in[0])); // R6

   AST_HOLD_FREEZE: assert property (@(posedge clk_in) disable iff (!clr_n || !free_armed)
      (clk_hold && $past(clk_hold)) |-> $stable(stage_q)); // R8

endmodule

bind piso_shreg piso_shreg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_in     (clk_in),
   .clk_hold   (clk_hold),
   .clr_n      (clr_n),
   .shift_mode (shift_mode),
   .ser_in     (ser_in),
   .par_in     (par_in),
   .edge_clk   (edge_clk),
   .stage_q    (stage_q)
);

// File: tb/tb_piso_shreg.sv
`timescale 1ns/1ps
module tb_piso_shreg;
   localparam int W = 8;

   logic sys_clk = 1'b1;
   always #2.5 sys_clk = ~sys_clk;   // 200 MHz

   logic         swap = 1'b0;
   logic         inh = 1'b1;
   logic         clr_n = 1'b0;
   logic         shift_mode = 1'b0;
   logic         ser_in = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         ser_out;
   logic         clk_a;
   logic         clk_b;

   // Normal: clk_in is the clock, clk_hold inhibits. Swapped: clk_in low, clk_hold clocks.
   assign clk_a = swap ? 1'b0 : sys_clk;
   assign clk_b = swap ? sys_clk : inh;

   piso_shreg #(.WIDTH(W)) dut (
      .clk_in     (clk_a),
      .clk_hold   (clk_b),
      .clr_n      (clr_n),
      .shift_mode (shift_mode),
      .ser_in     (ser_in),
      .par_in     (par_in),
      .ser_out    (ser_out)
   );

   int           checks = 0;
   int           errors = 0;
   bit           done = 0;
   logic [W-1:0] model = '0;
   bit           exp_q[$];
   string        tag_q[$];

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: ser_out=%b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic push(input bit e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // One cycle: inputs change while sys_clk is high, the active edge follows at its fall.
   task automatic op(input bit shf, input logic [W-1:0] par, input bit ser,
                     input bit hold, input string tag);
      @(posedge sys_clk);
      #1;
      clr_n = 1'b1; shift_mode = shf; par_in = par; ser_in = ser;
      if (!swap) inh = hold;
      #0.5;
      check({tag, " before edge (R4)"}, ser_out, model[W-1]);
      if (swap || !hold) model = shf ? {model[W-2:0], ser} : par;
      push(model[W-1], tag);
   endtask

   task automatic do_clear();
      @(posedge sys_clk);
      #1;
      clr_n = 1'b0; shift_mode = 1'b0; par_in = '1; ser_in = 1'b1; inh = 1'b0;
      #0.5;
      check("R1 clear acts at once", ser_out, 1'b0);
      model = '0;
      push(1'b0, "R2 edge during clear");
      @(posedge sys_clk);
      #1;
      shift_mode = 1'b1; par_in = 8'h81;
      push(1'b0, "R2 shift edge during clear");
   endtask

   // Role hand-over; a load of the current contents keeps the model unchanged.
   task automatic set_swap(input bit s);
      @(posedge sys_clk);
      #1;
      shift_mode = 1'b0; par_in = model;
      if (s) begin
         inh = 1'b1;
         #0.2 swap = 1'b1;
      end else begin
         swap = 1'b0;
         #0.2 inh = 1'b0;
      end
      push(model[W-1], "R7 hand-over");
   endtask

   initial begin : monitor
      forever begin
         @(negedge sys_clk);
         #1;
         if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, ser_out, e);
         end
      end
   end

   initial begin : watchdog
      #1ms;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(posedge sys_clk);
      #1 check("R1 reset state", ser_out, 1'b0);

      // Load with serial input high, then drain with zeros.
      op(1'b0, 8'hA5, 1'b1, 1'b0, "R3 load A5 (R6 serial ignored)");
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'b0, 1'b0, "R5 drain A5");
      for (int i = 0; i < 3; i++) op(1'b1, 8'hFF, 1'b0, 1'b0, "R9 stays zero");

      // Serial fill, then push it out.
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'(i % 3 == 0), 1'b0, "R5 serial fill");
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'b0, 1'b0, "R5 serial drain");

      // Parallel data changes between edges, with and without inhibit.
      op(1'b0, 8'h3C, 1'b0, 1'b0, "R3 load 3C");
      op(1'b0, 8'hC3, 1'b0, 1'b1, "R4 par change held");
      op(1'b0, 8'h81, 1'b1, 1'b1, "R4 par change held");
      op(1'b0, 8'hC3, 1'b0, 1'b0, "R3 load C3");

      // Loading zeros with serial input high leaves nothing behind.
      op(1'b0, 8'h00, 1'b1, 1'b0, "R6 load 00 ser=1");
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'b0, 1'b0, "R6 no serial bit entered");

      // Inhibit freezes shifts.
      op(1'b0, 8'h80, 1'b0, 1'b0, "R3 load 80");
      for (int i = 0; i < 3; i++) op(1'b1, 8'h00, 1'b0, 1'b1, "R8 inhibited shift");
      op(1'b1, 8'h00, 1'b0, 1'b0, "R8 shift after release");

      // Other leg as the clock.
      op(1'b0, 8'h96, 1'b0, 1'b0, "R3 load 96");
      set_swap(1'b1);
      op(1'b0, 8'h5A, 1'b1, 1'b1, "R7 load via clk_hold");
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'(i[0]), 1'b1, "R7 shift via clk_hold");
      set_swap(1'b0);
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'b0, 1'b0, "R7 drain via clk_in");

      // Clear in the middle of data.
      op(1'b0, 8'hFF, 1'b0, 1'b0, "R3 load FF");
      do_clear();
      for (int i = 0; i < W; i++) op(1'b1, 8'h00, 1'b0, 1'b0, "R2 cleared contents");

      // Mixed traffic.
      for (int i = 0; i < 60; i++)
         op(1'($urandom_range(0, 3) != 0), W'($urandom), 1'($urandom),
            1'($urandom_range(0, 4) == 0), "R5 mixed traffic");

      repeat (3) @(posedge sys_clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule